// File: doc/BRIEF.md
# Masked Legal-Combination Enumerator

This block walks through every legal setting of a 29-bit test-flag vector in ascending order. A test sequencer pulses `start` with a run-time mask of flags that the target cannot support; those flags stay zero for the whole run. After the pulse, the block presents the all-zero vector and then, on each cycle where the consumer raises `advance` while a vector is valid, steps to the next legal vector.

Stepping uses a masked increment. The mask bits are forced to one, one is added, and the mask bits are cleared again, so the carry passes straight over the masked positions. A candidate that breaks one of the fixed legality rules is dropped internally, at one candidate per clock, with `vec_valid` held low until a legal one is found. When the increment carries out of the top flag, `done` rises and stays high until the next `start`.

An optional physical-address-width input adds the reserved-address-bit flags to the mask when those bits would not be reserved on a target of that width.

Top module: `tfe_enum`

## Requirements
- R1: After reset, `vec_valid` and `done` are 0 and `vec` is 0. Before the first `start`, `advance` has no effect and `vec_valid` stays 0.
- R2: In the cycle after `start` is sampled high, `vec` is all zeros, `vec_valid` is 1 and `done` is 0. `start` restarts the enumeration at any time, including in the middle of a run and after `done`.
- R3: A step computes ((vec OR M) + 1) AND NOT M, where M is the effective mask captured at `start`. A bit set in M is never set in a valid vector. A step happens only when `vec_valid` and `advance` are both sampled high, so with `advance` low the vector holds.
- R4: A vector with bit 0 (write access) and bit 1 (instruction fetch) both set is illegal.
- R5: A vector with bit 2 (user-mode access) and bit 6 (supervisor execution prevention) both set is illegal.
- R6: A vector with bit 8 (key read-disable) or bit 9 (key write-disable) set while bit 7 (key enable) is clear is illegal.
- R7: A vector with bit 28 (directory reserved bit 13) set while bit 24 (directory large page) is clear is illegal. Of bits 26, 27 and 28 (directory reserved bits 51, 36 and 13), at most one may be set.
- R8: Of bits 17 and 18 (table-entry reserved bits 51 and 36), at most one may be set.
- R9: When `width_en` is high at `start`, a `phys_width` of 52 or more adds bits 17 and 26 to M, and a `phys_width` of 37 or more adds bits 18 and 27. When `width_en` is low, `phys_width` has no effect.
- R10: An illegal candidate is never presented. Only one candidate is examined per cycle, and `vec_valid` stays 0 until a legal one is reached. Valid vectors strictly increase.
- R11: When a step's sum reaches 2^29, `done` rises and `vec_valid` falls. Both hold, and `advance` is ignored, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new enumeration and capture the mask |
| inv_mask | input | 29 | Flags the target cannot support; they are held at zero |
| width_en | input | 1 | Derive the reserved-bit flags from `phys_width` |
| phys_width | input | 7 | Physical address width of the target, in bits |
| advance | input | 1 | Consumer accepts the current vector |
| vec | output | 29 | Current flag vector; meaningful while `vec_valid` is high |
| vec_valid | output | 1 | `vec` is a legal, unconsumed vector |
| done | output | 1 | Enumeration finished |

## Verification
The bound checker evaluates every legality rule (R4 to R8) against each valid vector on every cycle. On every cycle it also checks that masked bits are clear, that a stalled vector holds, that consumed vectors strictly increase, that `start` yields the zero vector, and that `done` is sticky. Only the bench's scenarios show the skip timing, the exact sequence of vectors, and the total count of vectors a mask produces, including the width-derived masks. The bench compares against a behavioural model on every clock and checks hand-computed counts for small free-bit sets.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    localparam int NFLAG = 29;

    // Flag positions; legality rules decode these
    localparam int F_WR    = 0;
    localparam int F_FETCH = 1;
    localparam int F_USER  = 2;
    localparam int F_TWICE = 3;
    localparam int F_NXE   = 4;
    localparam int F_WP    = 5;
    localparam int F_SEP   = 6;
    localparam int F_KEYEN = 7;
    localparam int F_KRD   = 8;
    localparam int F_KWR   = 9;
    localparam int F_KSEL  = 10;
    localparam int F_L_P   = 11;
    localparam int F_L_W   = 12;
    localparam int F_L_U   = 13;
    localparam int F_L_A   = 14;
    localparam int F_L_D   = 15;
    localparam int F_L_NX  = 16;
    localparam int F_L_R51 = 17;
    localparam int F_L_R36 = 18;
    localparam int F_D_P   = 19;
    localparam int F_D_W   = 20;
    localparam int F_D_U   = 21;
    localparam int F_D_A   = 22;
    localparam int F_D_D   = 23;
    localparam int F_D_LG  = 24;
    localparam int F_D_NX  = 25;
    localparam int F_D_R51 = 26;
    localparam int F_D_R36 = 27;
    localparam int F_D_R13 = 28;

    typedef logic [NFLAG-1:0] flags_t;

    typedef struct packed {
        flags_t cur;
        flags_t mask;
        logic   valid;
        logic   seek;
        logic   done;
    } tfe_state_t;

endpackage

// File: rtl/tfe_mask_derive.sv
module tfe_mask_derive
    import tfe_pkg::*;
#(
    parameter int WW        = 7,
    parameter int HI_LIMIT  = 52,
    parameter int MID_LIMIT = 37
) (
    input  flags_t          base,
    input  logic            width_en,
    input  logic [WW-1:0]   phys_width,
    output flags_t          eff
);
    localparam logic [WW-1:0] HI_W  = WW'(HI_LIMIT);
    localparam logic [WW-1:0] MID_W = WW'(MID_LIMIT);

    always_comb begin
        eff = base;
        if (width_en && (phys_width >= HI_W)) begin
            eff[F_L_R51] = 1'b1;
            eff[F_D_R51] = 1'b1;
        end
        if (width_en && (phys_width >= MID_W)) begin
            eff[F_L_R36] = 1'b1;
            eff[F_D_R36] = 1'b1;
        end
    end
endmodule

// File: rtl/tfe_rules.sv
module tfe_rules
    import tfe_pkg::*;
(
    input  flags_t cand,
    output logic   ok
);
    logic bad_acc, bad_sep, bad_key, bad_dir, bad_leaf;
    logic [1:0] dir_rsv_n;

    always_comb begin
        bad_acc   = cand[F_WR] & cand[F_FETCH];
        bad_sep   = cand[F_USER] & cand[F_SEP];
        bad_key   = ~cand[F_KEYEN] & (cand[F_KRD] | cand[F_KWR]);
        dir_rsv_n = 2'(cand[F_D_R51]) + 2'(cand[F_D_R36]) + 2'(cand[F_D_R13]);
        bad_dir   = (cand[F_D_R13] & ~cand[F_D_LG]) | (dir_rsv_n > 2'd1);
        bad_leaf  = cand[F_L_R51] & cand[F_L_R36];
        ok        = ~(bad_acc | bad_sep | bad_key | bad_dir | bad_leaf);
    end
endmodule

// File: rtl/tfe_masked_inc.sv
module tfe_masked_inc
    import tfe_pkg::*;
(
    input  flags_t cur,
    input  flags_t mask,
    output flags_t nxt,
    output logic   wrap
);
    logic [NFLAG:0] sum;

    always_comb begin
        sum  = {1'b0, cur | mask} + {{NFLAG{1'b0}}, 1'b1};
        wrap = sum[NFLAG];
        nxt  = sum[NFLAG-1:0] & ~mask;
    end
endmodule

// File: rtl/tfe_enum.sv
module tfe_enum
    import tfe_pkg::*;
#(
    parameter int WW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NFLAG-1:0]     inv_mask,
    input  logic                 width_en,
    input  logic [WW-1:0]        phys_width,
    input  logic                 advance,
    output logic [NFLAG-1:0]     vec,
    output logic                 vec_valid,
    output logic                 done
);
    tfe_state_t st_d, st_q;
    flags_t     eff_mask, cand, cur_mask;
    logic       cand_wrap, cand_ok, step;

    tfe_mask_derive #(.WW(WW)) u_mask (
        .base(inv_mask), .width_en(width_en), .phys_width(phys_width), .eff(eff_mask)
    );

    tfe_masked_inc u_inc (
        .cur(st_q.cur), .mask(st_q.mask), .nxt(cand), .wrap(cand_wrap)
    );

    tfe_rules u_rules (
        .cand(cand), .ok(cand_ok)
    );

    always_comb begin
        st_d = st_q;
        step = ((st_q.valid & advance) | st_q.seek) & ~st_q.done;
        if (start) begin
            st_d.mask  = eff_mask;
            st_d.cur   = '0;
            st_d.valid = 1'b1;
            st_d.seek  = 1'b0;
            st_d.done  = 1'b0;
        end else if (step) begin
            if (cand_wrap) begin
                st_d.valid = 1'b0;
                st_d.seek  = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.cur   = cand;
                st_d.valid = cand_ok;
                st_d.seek  = ~cand_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec       = st_q.cur;
    assign vec_valid = st_q.valid;
    assign done      = st_q.done;
    assign cur_mask  = st_q.mask;
endmodule

// File: rtl/tfe_enum_chk.sv
module tfe_enum_chk
    import tfe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       advance,
    input flags_t     vec,
    input logic       vec_valid,
    input logic       done,
    input flags_t     mask_q
);
    AST_NO_WR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !(vec[0] && vec[1])); // R4
    AST_NO_USER_SEP: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !(vec[2] && vec[6])); // R5
    AST_KEY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec[7]) |-> (!vec[8] && !vec[9])); // R6
    AST_DIR_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones(vec[28:26]) <= 1 && (!vec[28] || vec[24]))); // R7
    AST_LEAF_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $onehot0(vec[18:17])); // R8
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec & mask_q) == '0)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !advance && !start) |=> (vec_valid && $stable(vec))); // R3
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (vec_valid && vec == '0 && !done)); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !vec_valid)); // R11
    AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && advance && !start) |=> (done || vec > $past(vec))); // R10
endmodule

bind tfe_enum tfe_enum_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .vec(vec), .vec_valid(vec_valid), .done(done), .mask_q(cur_mask)
);

// File: tb/tfe_enum_test.sv
module tfe_enum_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n, start, width_en, advance;
    logic [28:0] inv_mask;
    logic [6:0]  phys_width;
    logic [28:0] vec;
    logic        vec_valid, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    tfe_enum uut (
        .clk(clk), .rst_n(rst_n), .start(start), .inv_mask(inv_mask),
        .width_en(width_en), .phys_width(phys_width), .advance(advance),
        .vec(vec), .vec_valid(vec_valid), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit ended   = 0;

    task automatic check(input bit cond, input string req, input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    longint m_cur, m_mask;
    bit     m_valid, m_seek, m_done;

    function automatic bit ref_legal(longint v);
        if (v[0] && v[1]) return 0;
        if (v[2] && v[6]) return 0;
        if (!v[7] && (v[8] || v[9])) return 0;
        if (v[28] && !v[24]) return 0;
        if ((int'(v[26]) + int'(v[27]) + int'(v[28])) > 1) return 0;
        if (v[17] && v[18]) return 0;
        return 1;
    endfunction

    function automatic longint ref_mask(longint base, bit en, int w);
        longint m = base;
        if (en && w >= 52) m = m | (longint'(1) << 17) | (longint'(1) << 26);
        if (en && w >= 37) m = m | (longint'(1) << 18) | (longint'(1) << 27);
        return m;
    endfunction

    always @(posedge clk) begin
        longint n;
        if (!rst_n) begin
            m_cur = 0; m_mask = 0; m_valid = 0; m_seek = 0; m_done = 0;
        end else if (start) begin
            m_mask = ref_mask(longint'(inv_mask), width_en, int'(phys_width));
            m_cur = 0; m_valid = 1; m_seek = 0; m_done = 0;
        end else if (((m_valid && advance) || m_seek) && !m_done) begin
            n = (m_cur | m_mask) + 1;
            if (n >= (longint'(1) << 29)) begin
                m_done = 1; m_valid = 0; m_seek = 0;
            end else begin
                m_cur = n & ~m_mask;
                m_valid = ref_legal(m_cur);
                m_seek = !m_valid;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !ended) begin
            check(vec_valid == m_valid, "R10 valid", longint'(vec_valid), longint'(m_valid));
            check(done == m_done, "R11 done", longint'(done), longint'(m_done));
            if (m_valid)
                check(longint'(vec) == m_cur, "R3 vector", longint'(vec), m_cur);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_case(input longint free, input bit wen, input int w,
                            input int expc, input string tag);
        int cnt = 0;
        int guard = 0;
        bit adv;
        @(negedge clk);
        inv_mask = ~free[28:0]; width_en = wen; phys_width = 7'(w);
        start = 1; advance = 0;
        @(negedge clk);
        start = 0;
        while (!done && guard < 5000) begin
            adv = ($urandom % 3) != 0;
            advance = adv;
            if (vec_valid && adv) cnt++;
            @(negedge clk);
            guard++;
        end
        advance = 0;
        check(cnt == expc, tag, cnt, expc);
    endtask

    function automatic longint bits(input int a, input int b = -1, input int c = -1, input int d = -1);
        longint r = longint'(1) << a;
        if (b >= 0) r |= longint'(1) << b;
        if (c >= 0) r |= longint'(1) << c;
        if (d >= 0) r |= longint'(1) << d;
        return r;
    endfunction

    initial begin
        rst_n = 0; start = 0; width_en = 0; advance = 0;
        inv_mask = '0; phys_width = '0;
        repeat (3) @(negedge clk);
        check(vec == 0 && !vec_valid && !done, "R1 reset", {vec_valid, done}, 0);
        rst_n = 1;
        advance = 1;
        repeat (3) @(negedge clk);
        check(!vec_valid && !done, "R1 advance before start", {vec_valid, done}, 0);
        advance = 0;

        // R2 + R3: zero first, stall holds, masked step
        inv_mask = ~29'h3; start = 1;
        @(negedge clk);
        start = 0;
        check(vec_valid && vec == 0 && !done, "R2 first zero", vec, 0);
        repeat (3) @(negedge clk);
        check(vec_valid && vec == 0, "R3 stall hold", vec, 0);
        advance = 1;
        @(negedge clk);
        advance = 0;
        check(vec_valid && vec == 29'h1, "R3 masked step", vec, 1);
        // R2: restart mid-run
        start = 1;
        @(negedge clk);
        start = 0;
        check(vec_valid && vec == 0, "R2 restart", vec, 0);

        run_case(bits(0, 1), 0, 0, 3, "R4 write/fetch count");
        run_case(bits(2, 6), 0, 0, 3, "R5 user/sep count");
        run_case(bits(7, 8, 9), 0, 0, 5, "R6 key count");
        run_case(bits(24, 26, 27, 28), 0, 0, 7, "R7 directory count");
        run_case(bits(17, 18, 3), 0, 0, 6, "R8 leaf count");
        run_case(bits(17, 18, 26, 27) | bits(3), 1, 52, 2, "R9 width 52");
        run_case(bits(17, 18, 26, 27) | bits(3), 1, 40, 8, "R9 width 40");
        run_case(bits(17, 18, 26, 27) | bits(3), 1, 36, 18, "R9 width 36");
        run_case(bits(17, 18, 26, 27) | bits(3), 0, 60, 18, "R9 width ignored");
        run_case(bits(4, 5, 11, 19), 0, 0, 16, "R10 unconstrained count");
        run_case(0, 0, 0, 1, "R11 full mask");

        // R11: done sticky, advance ignored
        advance = 1;
        repeat (5) @(negedge clk);
        check(done && !vec_valid, "R11 done sticky", {done, vec_valid}, 2);
        advance = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        check(!done && vec_valid && vec == 0, "R11 start clears done", {done, vec_valid}, 1);

        repeat (3) @(negedge clk);
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule